// File: doc/BRIEF.md
# Presettable Cascadable Up/Down Binary Counter

This block is a synchronous binary counter built from 4-bit slices. Each slice can be preset from a parallel data word, can count up or down, and drives an active-low ripple-carry that tells the next slice when to advance. The top module chains `STAGES` slices into one wide counter. Every slice shares the clock, the direction input and the parallel count enable. The least significant slice takes its trickle enable from a port, and each higher slice takes it from the carry of the slice below.

Each slice decides its operation from the control levels present at the rising clock edge, and only from those. The decoded operations are named `OP_LOAD`, `OP_HOLD`, `OP_UP` and `OP_DOWN`. The slice chooses between them with a fixed priority. If load is low, the operation is `OP_LOAD`. Otherwise, if either count enable is high, it is `OP_HOLD`. Otherwise the direction input selects `OP_UP` (high) or `OP_DOWN` (low).

The stored count is the slice state. Under `OP_UP` it moves to count+1, under `OP_DOWN` to count−1, under `OP_LOAD` to the data input, and under `OP_HOLD` it does not change. The carry is combinational from the trickle enable, the direction and the count. A synchronous active-high reset exists only to start simulation from zero.

Top module: `updn_chain`

## Requirements
- R1: When `rst` is high at a rising edge, the whole count becomes 0 at that edge, whatever the other inputs are.
- R2: When `rst` is low and `load_n` is low at a rising edge, `cnt` takes the value of `din` at that edge, and the enables and direction are ignored. Every value from 0 to 2^W−1 can be loaded.
- R3: When `load_n` is high, `en_par_n` and `en_tri_n` are both low and `dir_up` is high (1), `cnt` increases by one at the edge. It wraps from all ones to 0.
- R4: When `load_n` is high, both enables are low and `dir_up` is low (0), `cnt` decreases by one at the edge. It wraps from 0 to all ones.
- R5: When `load_n` is high and either `en_par_n` or `en_tri_n` is high, `cnt` keeps its value at the edge.
- R6: `carry_n` is low exactly when `en_tri_n` is low and the count is at its terminal value. The terminal value is all ones when `dir_up` is high and 0 when `dir_up` is low. `carry_n` follows its inputs without waiting for a clock edge.
- R7: In the chain, slice k (4 bits, slice 0 least significant) counts only when every slice below it is at its terminal value. As a result the full `cnt` behaves as a single W-bit binary counter, including across slice boundaries such as 0x0FF→0x100 and 0x100→0x0FF.
- R8: Changes on `load_n`, `en_par_n`, `en_tri_n`, `dir_up` or `din` between clock edges leave `cnt` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all slices |
| rst | input | 1 | Synchronous active-high clear, for simulation start |
| load_n | input | 1 | Active-low synchronous parallel load |
| dir_up | input | 1 | Count direction: 1 counts up, 0 counts down |
| en_par_n | input | 1 | Active-low parallel count enable, shared by all slices |
| en_tri_n | input | 1 | Active-low trickle enable of the least significant slice |
| din | input | STAGES*SLICE_W | Parallel preset value |
| cnt | output | STAGES*SLICE_W | Current count |
| carry_n | output | 1 | Active-low ripple-carry of the most significant slice |

## Verification
The hardest condition to reach from the ports is a carry that ripples through every slice at once. This needs the full count at all ones going up, or at zero going down, with the trickle enable low, at the moment of a clock edge. Free counting from random values would almost never arrive there within the run. So the random stimulus draws its preset values mostly from the terminal values, their neighbours and slice-boundary values such as 0x0FF and 0x100, and then lets the counter run in both directions across the wrap. A directed step also toggles every control input between two edges and checks that the count has not moved before the edge arrives.

// File: rtl/updn_pkg.sv
package updn_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_UP   = 2'd2,
        OP_DOWN = 2'd3
    } op_t;
endpackage

// File: rtl/updn_mode_dec.sv
module updn_mode_dec
    import updn_pkg::*;
(
    input  logic load_n,
    input  logic en_par_n,
    input  logic en_tri_n,
    input  logic dir_up,
    output op_t  op
);
    // Load outranks both enables; either enable high inhibits counting.
    always_comb begin
        if (!load_n)
            op = OP_LOAD;
        else if (en_par_n || en_tri_n)
            op = OP_HOLD;
        else if (dir_up)
            op = OP_UP;
        else
            op = OP_DOWN;
    end
endmodule

// File: rtl/updn_slice.sv
module updn_slice
    import updn_pkg::*;
#(
    parameter int SLICE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_n,
    input  logic               dir_up,
    input  logic               en_par_n,
    input  logic               en_tri_n,
    input  logic [SLICE_W-1:0] din,
    output logic [SLICE_W-1:0] q,
    output logic               carry_n
);
    localparam logic [SLICE_W-1:0] TOP_VAL = {SLICE_W{1'b1}};
    localparam logic [SLICE_W-1:0] ONE     = {{(SLICE_W-1){1'b0}}, 1'b1};

    op_t               op;
    logic [SLICE_W-1:0] q_nxt;
    logic               at_term;

    updn_mode_dec u_dec (
        .load_n   (load_n),
        .en_par_n (en_par_n),
        .en_tri_n (en_tri_n),
        .dir_up   (dir_up),
        .op       (op)
    );

    // Next-state selection
    always_comb begin
        unique case (op)
            OP_LOAD: q_nxt = din;
            OP_UP:   q_nxt = q + ONE;
            OP_DOWN: q_nxt = q - ONE;
            default: q_nxt = q;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= q_nxt;
    end

    // Output process: direction-dependent terminal count gated by trickle enable
    always_comb begin
        at_term = dir_up ? (q == TOP_VAL) : (q == '0);
        carry_n = !(!en_tri_n && at_term);
    end
endmodule

// File: rtl/updn_chain.sv
module updn_chain #(
    parameter int STAGES  = 3,
    parameter int SLICE_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load_n,
    input  logic                      dir_up,
    input  logic                      en_par_n,
    input  logic                      en_tri_n,
    input  logic [STAGES*SLICE_W-1:0] din,
    output logic [STAGES*SLICE_W-1:0] cnt,
    output logic                      carry_n
);
    logic [STAGES:0] tri_link;

    assign tri_link[0] = en_tri_n;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_slice
            updn_slice #(.SLICE_W(SLICE_W)) u_slice (
                .clk      (clk),
                .rst      (rst),
                .load_n   (load_n),
                .dir_up   (dir_up),
                .en_par_n (en_par_n),
                .en_tri_n (tri_link[k]),
                .din      (din[k*SLICE_W +: SLICE_W]),
                .q        (cnt[k*SLICE_W +: SLICE_W]),
                .carry_n  (tri_link[k+1])
            );
        end
    endgenerate

    assign carry_n = tri_link[STAGES];
endmodule

// File: rtl/updn_chain_chk.sv
module updn_chain_chk #(
    parameter int STAGES  = 3,
    parameter int SLICE_W = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      load_n,
    input logic                      dir_up,
    input logic                      en_par_n,
    input logic                      en_tri_n,
    input logic [STAGES*SLICE_W-1:0] din,
    input logic [STAGES*SLICE_W-1:0] cnt,
    input logic                      carry_n
);
    localparam int W = STAGES*SLICE_W;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic primed;
    always_ff @(posedge clk) primed <= 1'b1;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cnt == '0));

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> (cnt == $past(din)));

    assert_count_up_R3: assert property (@(posedge clk) disable iff (rst)
        (load_n && !en_par_n && !en_tri_n && dir_up) |=> (cnt == $past(cnt) + ONE));

    assert_count_down_R4: assert property (@(posedge clk) disable iff (rst)
        (load_n && !en_par_n && !en_tri_n && !dir_up) |=> (cnt == $past(cnt) - ONE));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (load_n && (en_par_n || en_tri_n)) |=> $stable(cnt));

    // R6: whole-chain carry seen from the ports
    always_comb begin
        if (primed && !rst)
            assert_carry_R6: assert (carry_n ==
                !(!en_tri_n && (dir_up ? (&cnt) : (cnt == '0))));
    end
endmodule

bind updn_chain updn_chain_chk #(.STAGES(STAGES), .SLICE_W(SLICE_W)) u_chk (.*);

// File: tb/updn_chain_tb.sv
module updn_chain_tb;
    localparam int STAGES  = 3;
    localparam int SLICE_W = 4;
    localparam int W       = STAGES*SLICE_W;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_n = 1'b1;
    logic         dir_up = 1'b1;
    logic         en_par_n = 1'b1;
    logic         en_tri_n = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] cnt;
    logic         carry_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    updn_chain #(.STAGES(STAGES), .SLICE_W(SLICE_W)) u_dut (
        .clk(clk), .rst(rst), .load_n(load_n), .dir_up(dir_up),
        .en_par_n(en_par_n), .en_tri_n(en_tri_n), .din(din),
        .cnt(cnt), .carry_n(carry_n)
    );

    function automatic logic [W-1:0] exp_next(logic [W-1:0] cur, logic ld, logic up,
                                              logic ep, logic et, logic [W-1:0] d);
        if (!ld)           return d;
        else if (ep || et) return cur;
        else if (up)       return cur + 1'b1;
        else               return cur - 1'b1;
    endfunction

    function automatic logic exp_carry(logic [W-1:0] cur, logic up, logic et);
        return !(!et && (up ? (cur == ALL1) : (cur == '0)));
    endfunction

    task automatic check_cnt(string req, logic [W-1:0] exp);
        n_tests++;
        if (cnt !== exp) begin
            n_fail++;
            $display("FAIL %s cnt actual=%h expected=%h", req, cnt, exp);
        end
    endtask

    task automatic check_carry(string req, logic exp);
        n_tests++;
        if (carry_n !== exp) begin
            n_fail++;
            $display("FAIL %s carry_n actual=%b expected=%b", req, carry_n, exp);
        end
    endtask

    // Called just after a falling edge: drive, check carry, clock, check count.
    task automatic cyc(string req, logic ld, logic up, logic ep, logic et, logic [W-1:0] d);
        logic [W-1:0] cur, exp;
        cur = cnt;
        load_n = ld; dir_up = up; en_par_n = ep; en_tri_n = et; din = d;
        #1;
        check_carry("R6", exp_carry(cur, up, et));
        exp = exp_next(cur, ld, up, ep, et, d);
        @(posedge clk);
        @(negedge clk);
        check_cnt(req, exp);
    endtask

    function automatic logic [W-1:0] pick_val(int unsigned r);
        case (r % 8)
            0: return '0;
            1: return ALL1;
            2: return ALL1 - 1'b1;
            3: return W'(1);
            4: return W'(12'h0FF);
            5: return W'(12'h100);
            default: return W'($urandom);
        endcase
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD*150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check_cnt("R1", '0);
        rst = 1'b0;

        // Reference style sequence on the low slice, inside a wide counter
        cyc("R2", 1'b0, 1'b1, 1'b1, 1'b1, W'(13));
        for (int i = 0; i < 5; i++) cyc("R3", 1'b1, 1'b1, 1'b0, 1'b0, '0);
        cyc("R5", 1'b1, 1'b1, 1'b1, 1'b0, '0);
        cyc("R5", 1'b1, 1'b0, 1'b0, 1'b1, '0);
        for (int i = 0; i < 5; i++) cyc("R4", 1'b1, 1'b0, 1'b0, 1'b0, '0);

        // Full-width wraps
        cyc("R2", 1'b0, 1'b1, 1'b0, 1'b0, ALL1 - 1'b1);
        cyc("R3", 1'b1, 1'b1, 1'b0, 1'b0, '0);
        cyc("R3", 1'b1, 1'b1, 1'b0, 1'b0, '0);
        check_cnt("R3", '0);
        cyc("R4", 1'b1, 1'b0, 1'b0, 1'b0, '0);
        check_cnt("R4", ALL1);

        // Slice boundary crossings
        cyc("R2", 1'b0, 1'b0, 1'b0, 1'b0, W'(12'h0FF));
        cyc("R7", 1'b1, 1'b1, 1'b0, 1'b0, '0);
        check_cnt("R7", W'(12'h100));
        cyc("R7", 1'b1, 1'b0, 1'b0, 1'b0, '0);
        check_cnt("R7", W'(12'h0FF));

        // Trickle enable high blocks carry at terminal
        cyc("R5", 1'b1, 1'b1, 1'b0, 1'b1, '0);

        // R8: mid-cycle toggling has no effect before the edge
        begin
            logic [W-1:0] held;
            held = cnt;
            load_n = 1'b0; din = ~held; en_par_n = 1'b0; en_tri_n = 1'b0; dir_up = ~dir_up;
            #2;
            check_cnt("R8", held);
            load_n = 1'b1; en_par_n = 1'b1; din = '0;
            #1;
            check_cnt("R8", held);
            cyc("R8", 1'b1, 1'b1, 1'b1, 1'b1, '0);
        end

        // Constrained random phase
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            logic ld, up, ep, et;
            r  = $urandom;
            ld = (r % 10) != 0;
            up = r[8];
            ep = (r[15:12] == 4'd0);
            et = (r[19:16] == 4'd0);
            cyc(!ld ? "R2" : (ep || et) ? "R5" : up ? "R3/R7" : "R4/R7",
                ld, up, ep, et, pick_val($urandom));
        end

        // Reset mid-run
        rst = 1'b1;
        load_n = 1'b0; din = ALL1;
        @(posedge clk);
        @(negedge clk);
        check_cnt("R1", '0);
        rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule